// File: doc/BRIEF.md
# Four-Stage Pipelined 16-bit Load/Store Processor Core

This block is a small 16-bit processor core that executes a program held in its own instruction array and keeps data in a separate data array. The two arrays sit side by side and are accessed independently. Each instruction passes through four stages: fetch, decode with operand read, ALU execute, and result write. A register stage separates each pair of neighbouring stages. When no stall occurs, one instruction finishes every clock. There are sixteen 16-bit general registers. Control is fixed decode logic with no microcode. There are no branches. The program runs straight through until it reaches a halt word or the last instruction address.

Both arrays are filled through a preload port while the core is held in reset. After reset is released, the core runs on its own. It raises `halt` once the program has stopped fetching and every stage is empty. Results are then read one register at a time through a debug read port. Read-after-write dependences are resolved by forwarding results from the execute and write stages into decode. An instruction that needs the value of the load just ahead of it waits one cycle.

Top module: `risc16_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the program counter is 0, no stage holds a valid instruction, `halt` is 0, and all sixteen registers read as zero.
- R2: Opcodes compute these 16-bit results from operands A and B, where s = B[3:0]: 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 ~A, 6 A<<s, 7 logical A>>s, 8 arithmetic A>>s, 9 rotate-left A by s, 10 rotate-right A by s, 11 A, 12 A+1, 13 A−1. Each wraps modulo 2^16.
- R3: In a register instruction, the opcode is [15:12], source A is [11:8], source B is [7:4] and the destination is [3:0]. A load (opcode 14) writes register [11:8] with data word [7:0]. A store (opcode 15) writes register [11:8] to data word [7:0].
- R4: An instruction whose source was written by either of the two instructions just before it reads the new value, with no stall.
- R5: An instruction that reads the destination of the load directly before it is held in decode for exactly one cycle. It then receives the loaded value.
- R6: A store writes its register value to the data array, and this value may come from a forwarded result. A later load from the same address returns that value.
- R7: The word 16'hFFFF is a halt word. It stops fetching and is not executed, and no instruction after it executes. `halt` rises only once no stage is valid, and then stays high until reset.
- R8: If no halt word is met, the instruction at the last instruction address is the final one executed, after which `halt` rises.
- R9: Count clock edges from the first rising edge after `rst` falls. Take N instructions that come before the stop point, and S load-use stalls. `halt` is first high after edge N+4+S.
- R10: `dbg_val` shows register `dbg_sel` one clock after `dbg_sel` is applied.
- R11: With `load_en` high, a rising edge writes `load_word` at `load_addr`. It writes to the data array when `load_to_data` is 1, using bits [7:0] of the address, and to the instruction array otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe |
| load_to_data | input | 1 | Preload target: 1 data array, 0 instruction array |
| load_addr | input | LD_AW (8) | Preload word address |
| load_word | input | 16 | Preload word |
| dbg_sel | input | 4 | Register index for debug read |
| dbg_val | output | 16 | Registered value of the selected register |
| halt | output | 1 | Program stopped and pipeline drained |

## Verification
A wrong forwarding choice or a missed stall leaves a wrong register value. This shows through the debug port once `halt` rises, a few dozen cycles after the bad instruction. A stall that was added or dropped by mistake, or a fetch that stops in the wrong place, moves the edge on which `halt` rises. So the bench compares the exact halt edge with N+4+S on every run. Each ALU operation is swept over an 8×8 operand grid. The loads in that sweep pass through the load-use path on operand B, and a dependent chain passes through it on operand A.

// File: rtl/risc16_pkg.sv
package risc16_pkg;
  localparam int XW   = 16;          // data and instruction width
  localparam int OPW  = 4;           // opcode field width
  localparam int RAW  = 4;           // register index width
  localparam int NREG = 1 << RAW;    // general registers
  localparam int DAW  = 8;           // data address field width
  localparam int SHW  = 4;           // shift amount width

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_AND  = 4'h2, OP_OR   = 4'h3,
    OP_XOR  = 4'h4, OP_NOT  = 4'h5, OP_SHL  = 4'h6, OP_SHR  = 4'h7,
    OP_SRA  = 4'h8, OP_ROL  = 4'h9, OP_ROR  = 4'hA, OP_PASS = 4'hB,
    OP_INC  = 4'hC, OP_DEC  = 4'hD, OP_LD   = 4'hE, OP_ST   = 4'hF
  } op_e;

  // true when the operation consumes the B register field
  function automatic logic reads_b(input op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
      OP_SHL, OP_SHR, OP_SRA, OP_ROL, OP_ROR: reads_b = 1'b1;
      default:                                reads_b = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/risc16_ram.sv
module risc16_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/risc16_regfile.sv
module risc16_regfile
  import risc16_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [XW-1:0]  wdata,
  input  logic [RAW-1:0] sel_a,
  output logic [XW-1:0]  val_a,
  input  logic [RAW-1:0] sel_b,
  output logic [XW-1:0]  val_b,
  input  logic [RAW-1:0] sel_c,
  output logic [XW-1:0]  val_c
);
  logic [XW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)                                  regs[g] <= '0;
      else if (we && waddr == RAW'(g))          regs[g] <= wdata;
    end
  end

  assign val_a = regs[sel_a];
  assign val_b = regs[sel_b];
  assign val_c = regs[sel_c];
endmodule

// File: rtl/risc16_alu.sv
module risc16_alu
  import risc16_pkg::*;
(
  input  op_e           op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y
);
  logic [SHW-1:0]  sh;
  logic [2*XW-1:0] rotl_w, rotr_w;

  assign sh     = b[SHW-1:0];
  assign rotl_w = {a, a} << sh;
  assign rotr_w = {a, a} >> sh;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_SRA:  y = $signed(a) >>> sh;
      OP_ROL:  y = rotl_w[2*XW-1:XW];
      OP_ROR:  y = rotr_w[XW-1:0];
      OP_PASS: y = a;
      OP_INC:  y = a + XW'(1);
      OP_DEC:  y = a - XW'(1);
      default: y = a;
    endcase
  end
endmodule

// File: rtl/risc16_core.sv
module risc16_core
  import risc16_pkg::*;
#(
  parameter int IMEM_AW = 8,
  localparam int LD_AW = (IMEM_AW > DAW) ? IMEM_AW : DAW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             load_to_data,
  input  logic [LD_AW-1:0] load_addr,
  input  logic [XW-1:0]    load_word,
  input  logic [RAW-1:0]   dbg_sel,
  output logic [XW-1:0]    dbg_val,
  output logic             halt
);
  localparam logic [IMEM_AW-1:0] PC_LAST   = '1;
  localparam logic [XW-1:0]      HALT_WORD = '1;

  // ---------------- fetch ----------------
  logic [IMEM_AW-1:0] pc;
  logic               stopped;
  logic               fd_valid;
  logic [XW-1:0]      fd_instr;
  logic               fetch_go;
  logic               stall;

  // ---------------- decode ----------------
  op_e            d_op;
  logic [RAW-1:0] d_ra, d_rb, d_rd;
  logic           d_halt, d_use_a, d_use_b, d_wr;
  logic [XW-1:0]  rf_a, rf_b, rf_dbg;
  logic [XW-1:0]  opa, opb;

  // ---------------- execute ----------------
  logic           de_valid;
  op_e            de_op;
  logic [RAW-1:0] de_rd;
  logic           de_wr;
  logic [XW-1:0]  de_a, de_b;
  logic [DAW-1:0] de_addr;
  logic [XW-1:0]  alu_y;
  logic           st_fire, e_fwd;

  // ---------------- write ----------------
  logic           ew_valid;
  logic           ew_ld;
  logic [RAW-1:0] ew_rd;
  logic           ew_wr;
  logic [XW-1:0]  ew_res;
  logic [XW-1:0]  dm_q;
  logic [XW-1:0]  wb_val;
  logic           w_fwd;

  // ---------------- data array port mux ----------------
  logic           dm_load, dm_we;
  logic [DAW-1:0] dm_waddr;
  logic [XW-1:0]  dm_wdata;

  // instruction array: preload writes, fetch reads (read register = fetch/decode stage)
  risc16_ram #(.AW(IMEM_AW), .DW(XW)) u_imem (
    .clk   (clk),
    .we    (load_en && !load_to_data),
    .waddr (load_addr[IMEM_AW-1:0]),
    .wdata (load_word),
    .re    (fetch_go),
    .raddr (pc),
    .rdata (fd_instr)
  );

  // decode fields
  assign d_op    = op_e'(fd_instr[XW-1:XW-OPW]);
  assign d_ra    = fd_instr[11:8];
  assign d_rb    = fd_instr[7:4];
  assign d_halt  = fd_valid && (fd_instr == HALT_WORD);
  assign d_use_a = (d_op != OP_LD);
  assign d_use_b = reads_b(d_op);
  assign d_rd    = (d_op == OP_LD) ? fd_instr[11:8] : fd_instr[3:0];
  assign d_wr    = (d_op != OP_ST);

  risc16_regfile u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (ew_valid && ew_wr),
    .waddr (ew_rd),
    .wdata (wb_val),
    .sel_a (d_ra),
    .val_a (rf_a),
    .sel_b (d_rb),
    .val_b (rf_b),
    .sel_c (dbg_sel),
    .val_c (rf_dbg)
  );

  // forwarding sources: execute result (not for loads) and write-stage value
  assign e_fwd  = de_valid && de_wr && (de_op != OP_LD);
  assign w_fwd  = ew_valid && ew_wr;
  assign wb_val = ew_ld ? dm_q : ew_res;

  always_comb begin
    if (e_fwd && de_rd == d_ra)      opa = alu_y;
    else if (w_fwd && ew_rd == d_ra) opa = wb_val;
    else                             opa = rf_a;
    if (e_fwd && de_rd == d_rb)      opb = alu_y;
    else if (w_fwd && ew_rd == d_rb) opb = wb_val;
    else                             opb = rf_b;
  end

  // load-use interlock: data from a load in execute is not ready until write
  assign stall = fd_valid && !d_halt && de_valid && (de_op == OP_LD) &&
                 ((d_use_a && d_ra == de_rd) || (d_use_b && d_rb == de_rd));

  assign fetch_go = !stopped && !d_halt && !stall;

  // control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      stopped  <= 1'b0;
      fd_valid <= 1'b0;
      de_valid <= 1'b0;
      ew_valid <= 1'b0;
      halt     <= 1'b0;
    end else begin
      if (!stall) begin
        fd_valid <= fetch_go;
        if (fetch_go) begin
          if (pc == PC_LAST) stopped <= 1'b1;
          else               pc      <= pc + IMEM_AW'(1);
        end
      end
      if (d_halt) stopped <= 1'b1;
      de_valid <= fd_valid && !d_halt && !stall;
      ew_valid <= de_valid;
      halt     <= stopped && !fd_valid && !de_valid && !ew_valid;
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    de_op   <= d_op;
    de_rd   <= d_rd;
    de_wr   <= d_wr;
    de_a    <= opa;
    de_b    <= opb;
    de_addr <= fd_instr[DAW-1:0];
    ew_ld   <= (de_op == OP_LD);
    ew_rd   <= de_rd;
    ew_wr   <= de_wr;
    ew_res  <= alu_y;
    dbg_val <= rf_dbg;
  end

  risc16_alu u_alu (
    .op (de_op),
    .a  (de_a),
    .b  (de_b),
    .y  (alu_y)
  );

  // data array: preload has priority over a store
  assign st_fire  = de_valid && (de_op == OP_ST);
  assign dm_load  = load_en && load_to_data;
  assign dm_we    = dm_load || st_fire;
  assign dm_waddr = dm_load ? load_addr[DAW-1:0] : de_addr;
  assign dm_wdata = dm_load ? load_word : de_a;

  risc16_ram #(.AW(DAW), .DW(XW)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .re    (1'b1),
    .raddr (de_addr),
    .rdata (dm_q)
  );
endmodule

// File: rtl/risc16_chk.sv
module risc16_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          halt,
  input logic          stall,
  input logic          stopped,
  input logic          fd_valid,
  input logic          de_valid,
  input logic          ew_valid,
  input logic [AW-1:0] pc
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && !fd_valid && !de_valid && !ew_valid && !halt));

  // R5
  stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!de_valid && $stable(pc)));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R7
  halt_drained_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!fd_valid && !de_valid && !ew_valid));

  // R7
  no_fetch_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stopped |=> $stable(pc));

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> (pc == $past(pc) + AW'(1)));
endmodule

bind risc16_core risc16_chk #(.AW(IMEM_AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .halt     (halt),
  .stall    (stall),
  .stopped  (stopped),
  .fd_valid (fd_valid),
  .de_valid (de_valid),
  .ew_valid (ew_valid),
  .pc       (pc)
);

// File: tb/tb_risc16_core.sv
`timescale 1ns/1ps
module tb_risc16_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_en, load_to_data;
  logic [7:0]  load_addr;
  logic [15:0] load_word;
  logic [3:0]  dbg_sel;
  logic [15:0] dbg_val;
  logic        halt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] prog  [256];
  logic [15:0] dinit [8];

  always #2.5 clk = ~clk;

  risc16_core dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_to_data(load_to_data),
    .load_addr(load_addr), .load_word(load_word),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val), .halt(halt)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cyc);
        summary();
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rr(input int op, input int a, input int b, input int d);
    return {op[3:0], a[3:0], b[3:0], d[3:0]};
  endfunction

  function automatic logic [15:0] mem_op(input int op, input int r, input int addr);
    return {op[3:0], r[3:0], addr[7:0]};
  endfunction

  function automatic logic [15:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
    int s;
    logic [15:0] r;
    s = int'(b[3:0]);
    case (op)
      0:  r = a + b;
      1:  r = a - b;
      2:  r = a & b;
      3:  r = a | b;
      4:  r = a ^ b;
      5:  r = ~a;
      6:  r = a << s;
      7:  r = a >> s;
      8:  r = (a >> s) | (a[15] ? ~(16'hFFFF >> s) : 16'h0000);
      9:  r = (s == 0) ? a : ((a << s) | (a >> (16 - s)));
      10: r = (s == 0) ? a : ((a >> s) | (a << (16 - s)));
      11: r = a;
      12: r = a + 16'd1;
      default: r = a - 16'd1;
    endcase
    return r;
  endfunction

  // R10: value appears one clock after the index is applied
  task automatic read_reg(input int r, output logic [15:0] v);
    @(negedge clk);
    dbg_sel = r[3:0];
    @(posedge clk);
    @(negedge clk);
    v = dbg_val;
  endtask

  // R11 preload under reset, then run until halt; R9 halt edge count
  task automatic run_prog(input int exp_edges, input string tag);
    int edges;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_to_data = 1'b0; load_addr = i[7:0]; load_word = prog[i];
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_to_data = 1'b1; load_addr = i[7:0]; load_word = dinit[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    rst = 1'b0;
    edges = 0;
    while (!halt && edges < 2000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    check(edges == exp_edges, tag, edges, exp_edges);
  endtask

  initial begin
    logic [15:0] v, e, a, b;
    logic [15:0] vals [8];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'hA5C3; vals[7] = 16'h00F7;

    rst = 1'b1; load_en = 1'b0; load_to_data = 1'b0; load_addr = '0; load_word = '0; dbg_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(halt == 1'b0, "R1 halt low in reset", halt, 0);

    // ---- dependent chain: R4, R5, R6, R7, R9 ----
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
    for (int i = 0; i < 8; i++) dinit[i] = 16'h0000;
    dinit[0] = 16'h1234;
    prog[0] = mem_op(14, 1, 0);      // r1 <- d[0]
    prog[1] = rr(12, 1, 0, 2);       // r2 = r1+1 (load-use on A)
    prog[2] = rr(0, 2, 2, 3);        // r3 = r2+r2 (execute forward)
    prog[3] = rr(1, 3, 2, 4);        // r4 = r3-r2 (execute + write forward)
    prog[4] = rr(4, 4, 1, 5);        // r5 = r4^r1
    prog[5] = mem_op(15, 5, 5);      // d[5] <- r5 (forwarded store data)
    prog[6] = mem_op(14, 6, 5);      // r6 <- d[5]
    prog[7] = rr(0, 6, 6, 7);        // r7 = r6+r6 (load-use)
    prog[8] = 16'hFFFF;              // halt word
    prog[9] = rr(12, 8, 0, 8);       // must never execute
    run_prog(8 + 4 + 2, "R9/R5 chain halt edge");
    a = 16'h1234;
    read_reg(1, v); check(v == a, "R3 load dest", v, a);
    e = a + 16'd1;
    read_reg(2, v); check(v == e, "R5 load-use result", v, e);
    b = e + e;
    read_reg(3, v); check(v == b, "R4 execute forward", v, b);
    b = b - e;
    read_reg(4, v); check(v == b, "R4 write-stage forward", v, b);
    b = b ^ a;
    read_reg(5, v); check(v == b, "R4 regfile read", v, b);
    read_reg(6, v); check(v == b, "R6 store then load", v, b);
    e = b + b;
    read_reg(7, v); check(v == e, "R5 load-use on loaded store", v, e);
    read_reg(8, v); check(v == 16'h0000, "R7 after-halt not executed", v, 0);
    check(halt == 1'b1, "R7 halt stays high", halt, 1);

    // ---- reset clears registers: R1 ----
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int r = 0; r < 16; r++) begin
      read_reg(r, v);
      check(v == 16'h0000, "R1 register cleared", v, 0);
    end
    check(halt == 1'b0, "R1 halt cleared", halt, 0);

    // ---- ALU sweep: R2, R3, R5, R9, R10, R11 ----
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
        dinit[0] = vals[ia];
        dinit[1] = vals[ib];
        prog[0] = mem_op(14, 1, 0);
        prog[1] = mem_op(14, 2, 1);
        for (int k = 0; k < 14; k++)
          prog[2 + k] = rr(k, 1, 2, (k == 13) ? 0 : k + 3);
        prog[16] = 16'hFFFF;
        run_prog(16 + 4 + 1, "R9 sweep halt edge");
        for (int k = 0; k < 14; k++) begin
          read_reg((k == 13) ? 0 : k + 3, v);
          e = model(k, vals[ia], vals[ib]);
          check(v == e, $sformatf("R2 op %0d a=%h b=%h", k, vals[ia], vals[ib]), v, e);
        end
      end
    end

    // ---- run to end of instruction array: R8 ----
    for (int i = 0; i < 256; i++) prog[i] = rr(12, 1, 0, 1);
    for (int i = 0; i < 8; i++) dinit[i] = 16'h0000;
    run_prog(256 + 4, "R8 end-of-array halt edge");
    read_reg(1, v);
    check(v == 16'd256, "R8 all instructions executed", v, 256);

    summary();
    $finish;
  end
endmodule